// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor that completes one instruction in every clock cycle. It works on a fixed 32-bit encoding with three layouts: register-register, register-immediate and jump. Each cycle it fetches the word that the program counter points at, decodes it, and reads two operands from a 32-entry register file. The ALU then produces a result or a memory address. The result, or the loaded data, is written back and the program counter moves on, all on the same rising edge.

Instruction memory and data memory sit outside the block on two separate ports. The instruction port carries a word address and takes the fetched word back in the same cycle. The data port carries a byte address, a write strobe and write data, and takes read data back in the same cycle. The supported operations are add, sub, and, or, nor, set-less-than, register jump, add-immediate, the three zero-extended logical immediates, upper-immediate load, word load, word store and the absolute jump.

Top module: `rcore_top`

## Requirements
- R1: While reset is high, the program counter is cleared on each rising edge, so the fetch word address is 0 in the first cycle after reset.
- R2: Any instruction other than a jump or a register jump moves the program counter on by 4, so the fetch word address grows by 1.
- R3: R-type (opcode 0) with funct 32, 34, 36, 37 or 39 writes rs+rt, rs-rt, rs AND rt, rs OR rt or NOT(rs OR rt) into register rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R4: R-type funct 42 writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. Opcodes 12, 13 and 14 write rs AND, OR or XOR the zero-extended immediate into rt.
- R6: Opcode 15 writes the immediate into bits 31:16 of rt and clears bits 15:0.
- R7: Opcodes 35 (load) and 43 (store) form the byte address rs + sign-extended immediate, which may be negative. A store raises the write strobe for that cycle only and drives the value of rt. A load writes the data read into rt.
- R8: Opcode 2 sets the program counter to the upper 4 bits of the current counter, then instruction bits 25:0, then two zero bits.
- R9: R-type funct 8 sets the program counter to the full 32-bit value of rs.
- R10: Register 0 always reads as zero. Any write to it is discarded.
- R11: An undefined opcode, or an undefined funct under opcode 0, writes no register and does not strobe memory, but it still moves the program counter on by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 30 | Word address of the instruction to fetch (PC bits 31:2) |
| imem_rdata | input | 32 | Fetched instruction word, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a data load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Load data, valid in the same cycle |

## Verification
The bench uses operand values whose sign bit is set, so that set-less-than is checked as a signed compare. A core that compared unsigned would store 0 where 1 is expected. It mixes sign-extended and zero-extended immediates with the same 0xFxxx pattern, so a core that extends the wrong way shows all-ones upper bits in the stored words. A store at a negative offset would land at the wrong address if the offset were not sign-extended. A load whose result is used by the very next instruction checks that the loaded data, and not the address, is written back. An instruction is placed just after each kind of jump, and that instruction writes a register that is stored later. A core that fell through either jump would leave a nonzero value in that register. A write aimed at register 0 is followed by a store of register 0, and an undefined opcode and an undefined funct are each followed by a store of the register they name. A core with a live register 0, or one that executes undefined encodings, would store nonzero data there.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN  = 32;
    localparam int NREG  = 32;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_XORI  = 6'd14;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_JREG  = 6'd8;
    localparam logic [5:0] FN_ADD   = 6'd32;
    localparam logic [5:0] FN_SUB   = 6'd34;
    localparam logic [5:0] FN_AND   = 6'd36;
    localparam logic [5:0] FN_OR    = 6'd37;
    localparam logic [5:0] FN_NOR   = 6'd39;
    localparam logic [5:0] FN_SLT   = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_XOR, ALU_SLT, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN, IMM_ZERO, IMM_UPPER
    } imm_kind_e;

    typedef enum logic [1:0] {
        NPC_SEQ, NPC_JUMP, NPC_REG
    } npc_sel_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_is_rd;
        logic      use_imm;
        imm_kind_e imm_kind;
        alu_op_e   alu_op;
        logic      mem_we;
        logic      load;
        npc_sel_e  npc;
    } ctrl_t;

    // Control word for one opcode/funct pair; unknown encodings give a no-op.
    function automatic ctrl_t decode_ctrl(input logic [5:0] op, input logic [5:0] fn);
        ctrl_t c;
        c          = '0;
        c.imm_kind = IMM_SIGN;
        c.alu_op   = ALU_ADD;
        c.npc      = NPC_SEQ;
        case (op)
            OP_RTYPE: begin
                c.dst_is_rd = 1'b1;
                case (fn)
                    FN_ADD:  begin c.reg_we = 1'b1; c.alu_op = ALU_ADD; end
                    FN_SUB:  begin c.reg_we = 1'b1; c.alu_op = ALU_SUB; end
                    FN_AND:  begin c.reg_we = 1'b1; c.alu_op = ALU_AND; end
                    FN_OR:   begin c.reg_we = 1'b1; c.alu_op = ALU_OR;  end
                    FN_NOR:  begin c.reg_we = 1'b1; c.alu_op = ALU_NOR; end
                    FN_SLT:  begin c.reg_we = 1'b1; c.alu_op = ALU_SLT; end
                    FN_JREG: c.npc = NPC_REG;
                    default: ;
                endcase
            end
            OP_JUMP: c.npc = NPC_JUMP;
            OP_ADDI: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_SIGN; c.alu_op = ALU_ADD;
            end
            OP_ANDI: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_ZERO; c.alu_op = ALU_AND;
            end
            OP_ORI: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_ZERO; c.alu_op = ALU_OR;
            end
            OP_XORI: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_ZERO; c.alu_op = ALU_XOR;
            end
            OP_LUI: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_UPPER; c.alu_op = ALU_PASSB;
            end
            OP_LOAD: begin
                c.reg_we = 1'b1; c.use_imm = 1'b1; c.load = 1'b1;
                c.imm_kind = IMM_SIGN; c.alu_op = ALU_ADD;
            end
            OP_STORE: begin
                c.mem_we = 1'b1; c.use_imm = 1'b1;
                c.imm_kind = IMM_SIGN; c.alu_op = ALU_ADD;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NR   = NREG,
    localparam int AW  = $clog2(NR)
) (
    input  logic [31:0]   instr,
    output ctrl_t         ctrl,
    output logic [AW-1:0] rs_idx,
    output logic [AW-1:0] rt_idx,
    output logic [AW-1:0] wr_idx,
    output logic [W-1:0]  imm_val,
    output logic [25:0]   jtarget
);
    logic [15:0] imm16;

    assign imm16   = instr[15:0];
    assign jtarget = instr[25:0];
    assign rs_idx  = instr[21 +: AW];
    assign rt_idx  = instr[16 +: AW];

    always_comb begin
        ctrl   = decode_ctrl(instr[31:26], instr[5:0]);
        wr_idx = ctrl.dst_is_rd ? instr[11 +: AW] : instr[16 +: AW];
    end

    always_comb begin
        case (ctrl.imm_kind)
            IMM_ZERO:  imm_val = {{(W-16){1'b0}}, imm16};
            IMM_UPPER: imm_val = {imm16, {(W-16){1'b0}}};
            default:   imm_val = {{(W-16){imm16[15]}}, imm16};
        endcase
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int W   = 32,
    parameter int N   = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] bank [N];

    // Entry 0 is wired to zero and has no storage.
    assign bank[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_entry
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && wa == AW'(g))
                q <= wd;
        end
        assign bank[g] = q;
    end

    assign rd_a = bank[ra_a];
    assign rd_b = bank[ra_b];
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    logic lt;

    assign lt = $signed(a) < $signed(b);

    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_NOR:   y = ~(a | b);
            ALU_XOR:   y = a ^ b;
            ALU_SLT:   y = {{(W-1){1'b0}}, lt};
            default:   y = b;
        endcase
    end
endmodule

// File: rtl/core_pc.sv
module core_pc
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  npc_sel_e     sel,
    input  logic [25:0]  jtarget,
    input  logic [W-1:0] reg_target,
    output logic [W-1:0] pc
);
    logic [W-1:0] pc_next;

    always_comb begin
        case (sel)
            NPC_JUMP: pc_next = {pc[W-1 -: 4], jtarget, 2'b00};
            NPC_REG:  pc_next = reg_target;
            default:  pc_next = pc + W'(4);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else
            pc <= pc_next;
    end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import core_pkg::*;
#(
    parameter int XW  = XLEN,
    parameter int NR  = NREG,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-3:0] imem_addr,
    input  logic [31:0]   imem_rdata,
    output logic [XW-1:0] dmem_addr,
    output logic [XW-1:0] dmem_wdata,
    output logic          dmem_we,
    input  logic [XW-1:0] dmem_rdata
);
    ctrl_t          ctrl;
    logic [AW-1:0]  rs_idx, rt_idx, wr_idx;
    logic [XW-1:0]  imm_val, rs_data, rt_data, alu_b, alu_y, wb_data, pc;
    logic [25:0]    jtarget;

    core_decode #(.W(XW), .NR(NR)) u_dec (
        .instr   (imem_rdata),
        .ctrl    (ctrl),
        .rs_idx  (rs_idx),
        .rt_idx  (rt_idx),
        .wr_idx  (wr_idx),
        .imm_val (imm_val),
        .jtarget (jtarget)
    );

    core_regfile #(.W(XW), .N(NR)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (rs_idx),
        .ra_b (rt_idx),
        .rd_a (rs_data),
        .rd_b (rt_data),
        .we   (ctrl.reg_we),
        .wa   (wr_idx),
        .wd   (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_val : rt_data;

    core_alu #(.W(XW)) u_alu (
        .a  (rs_data),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    assign wb_data = ctrl.load ? dmem_rdata : alu_y;

    core_pc #(.W(XW)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .sel        (ctrl.npc),
        .jtarget    (jtarget),
        .reg_target (rs_data),
        .pc         (pc)
    );

    assign imem_addr  = pc[XW-1:2];
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_data;
    assign dmem_we    = ctrl.mem_we;
endmodule

// File: rtl/rcore_checker.sv
module rcore_checker #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [XW-3:0] imem_addr,
    input logic [31:0]   imem_rdata,
    input logic          dmem_we,
    input logic [XW-1:0] rs_data
);
    logic [5:0] op, fn;
    logic       is_j, is_jr;

    assign op    = imem_rdata[31:26];
    assign fn    = imem_rdata[5:0];
    assign is_j  = (op == 6'd2);
    assign is_jr = (op == 6'd0) && (fn == 6'd8);

    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> imem_addr == '0);

    a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
        (!is_j && !is_jr) |=> imem_addr == $past(imem_addr) + 1'b1);

    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        is_j |=> imem_addr == {$past(imem_addr[XW-3 -: 4]), $past(imem_rdata[25:0])});

    a_r9_jreg_target: assert property (@(posedge clk) disable iff (rst)
        is_jr |=> imem_addr == $past(rs_data[XW-1:2]));

    a_r10_zero_read: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[25:21] == 5'd0) |-> rs_data == '0);

    a_r11_store_only: assert property (@(posedge clk) disable iff (rst)
        (op != 6'd43) |-> !dmem_we);
endmodule

bind rcore_top rcore_checker #(.XW(XW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .rs_data    (rs_data)
);

// File: tb/rcore_top_tb.sv
module rcore_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcore_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    // Reference model state
    logic [31:0] mpc;
    logic [31:0] mreg [32];
    string       mtag [32];
    logic [31:0] mmem [64];
    string       pc_tag;
    int          pidx;

    function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word_target);
        return {6'd2, 26'(word_target)};
    endfunction

    task automatic put(logic [31:0] w);
        imem[pidx] = w;
        pidx++;
    endtask

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] ins, a, b, se, ze, val, npc, ea;
        logic [5:0]  op, fn;
        int          rs, rt, rd, widx;
        string       wtag, ntag, ctag;
        bit          exp_we;
        ins = imem[mpc[7:2]];
        check(imem_addr == mpc[31:2], pc_tag, "fetch address", {2'b00, imem_addr}, {2'b00, mpc[31:2]});
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a  = mreg[rs]; b = mreg[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'd0, ins[15:0]};
        ea = a + se;
        widx = -1; val = '0; wtag = "R11"; exp_we = 1'b0;
        npc = mpc + 4; ntag = "R2"; ctag = "R11";
        case (op)
            6'd0: begin
                ctag = "R3";
                case (fn)
                    6'd32: begin widx = rd; val = a + b;    wtag = "R3"; end
                    6'd34: begin widx = rd; val = a - b;    wtag = "R3"; end
                    6'd36: begin widx = rd; val = a & b;    wtag = "R3"; end
                    6'd37: begin widx = rd; val = a | b;    wtag = "R3"; end
                    6'd39: begin widx = rd; val = ~(a | b); wtag = "R3"; end
                    6'd42: begin widx = rd; val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; wtag = "R4"; end
                    6'd8:  begin npc = a; ntag = "R9"; ctag = "R9"; end
                    default: ctag = "R11";
                endcase
            end
            6'd2:  begin npc = {mpc[31:28], ins[25:0], 2'b00}; ntag = "R8"; ctag = "R8"; end
            6'd8:  begin widx = rt; val = a + se;              wtag = "R5"; ctag = "R5"; end
            6'd12: begin widx = rt; val = a & ze;              wtag = "R5"; ctag = "R5"; end
            6'd13: begin widx = rt; val = a | ze;              wtag = "R5"; ctag = "R5"; end
            6'd14: begin widx = rt; val = a ^ ze;              wtag = "R5"; ctag = "R5"; end
            6'd15: begin widx = rt; val = {ins[15:0], 16'd0};  wtag = "R6"; ctag = "R6"; end
            6'd35: begin widx = rt; val = mmem[ea[7:2]];       wtag = "R7"; ctag = "R7"; end
            6'd43: begin exp_we = 1'b1; ctag = "R7"; end
            default: ctag = "R11";
        endcase
        check(dmem_we == exp_we, ctag, "store strobe", {31'd0, dmem_we}, {31'd0, exp_we});
        if (exp_we) begin
            check(dmem_addr == ea, "R7", "store address", dmem_addr, ea);
            check(dmem_wdata == b, mtag[rt], "stored register value", dmem_wdata, b);
            mmem[ea[7:2]] = b;
        end
        if (widx > 0) begin
            mreg[widx] = val;
            mtag[widx] = wtag;
        end
        mpc    = npc;
        pc_tag = ntag;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dmem[i] = '0;
            mmem[i] = '0;
        end
        for (int i = 0; i < 32; i++) begin
            mreg[i] = '0;
            mtag[i] = "R11";
        end
        mtag[0]  = "R10";
        mtag[19] = "R9";
        mtag[20] = "R8";
        mpc      = '0;
        pc_tag   = "R2";
        pidx     = 0;

        put(enc_i(15, 0, 1, 16'h8000));       // R6 lui
        put(enc_i(13, 1, 1, 16'h0005));       // R5 ori
        put(enc_i(8, 0, 2, 16'hFFFD));        // R5 addi -3
        put(enc_i(8, 0, 3, 7));
        put(enc_r(32, 2, 3, 4));              // R3 add
        put(enc_r(34, 2, 3, 5));              // R3 sub
        put(enc_r(36, 1, 2, 6));
        put(enc_r(37, 1, 3, 7));
        put(enc_r(39, 2, 3, 8));
        put(enc_r(42, 1, 3, 9));              // R4 negative < positive
        put(enc_r(42, 3, 2, 10));             // R4 positive vs negative
        put(enc_i(12, 2, 11, 16'hFFF0));      // R5 andi zero-extended
        put(enc_i(14, 3, 12, 16'h8001));      // R5 xori zero-extended
        put(enc_i(8, 0, 0, 5));               // R10 write to r0
        put(enc_i(8, 0, 14, 128));
        put(enc_i(8, 0, 15, 192));
        for (int r = 1; r <= 12; r++) put(enc_i(43, 14, r, (r - 1) * 4));
        put(enc_i(43, 14, 0, 48));            // R10 store r0
        put(enc_i(43, 15, 4, 16'hFFFC));      // R7 negative offset
        put(enc_i(35, 14, 16, 8));            // R7 load
        put(enc_i(35, 15, 21, 16'hFFFC));
        put(enc_r(32, 16, 21, 16));           // loaded data used next cycle
        put(enc_i(43, 15, 16, 0));
        put({6'h3F, 5'd0, 5'd17, 16'h1234});  // R11 undefined opcode
        put(enc_r(63, 3, 3, 17));             // R11 undefined funct
        put(enc_i(43, 15, 17, 4));
        put(enc_i(8, 0, 18, (pidx + 3) * 4)); // R9 target
        put(enc_r(8, 18, 0, 0));
        put(enc_i(8, 0, 19, 99));             // skipped by register jump
        put(enc_i(43, 15, 19, 8));
        put(enc_j(pidx + 2));                 // R8
        put(enc_i(8, 0, 20, 77));             // skipped by jump
        put(enc_i(43, 15, 20, 12));
        put(enc_i(43, 15, 18, 16));
        put(enc_j(pidx));                     // park

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == '0, "R1", "fetch address in reset", {2'b00, imem_addr}, 32'd0);
        check(dmem_we == 1'b0, "R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        for (int s = 0; s < STEPS; s++) begin
            model_step();
            @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule